// File: doc/BRIEF.md
# DC-Balanced Embedded-Clock Frame Serializer

This block turns a 24-bit parallel word into a 28-bit serial frame and sends the frame out one bit per bit-clock cycle. The block runs on the fast bit clock, which is 28 times the parallel rate. The parallel clock arrives as a sampled input. On each edge of the parallel clock chosen by a select pin, the block captures the parallel word. Each frame wraps the payload with a fixed high marker bit and a fixed low marker bit, which give the receiver an embedded clock edge to lock to. It also adds a balance bit and a parity bit. The balance bit records whether the payload went out inverted. The block chooses inversion so that a signed running disparity stays close to zero.

A small state machine runs the link. In `ST_IDLE` nothing is sent. The transition *start* goes to `ST_FILL` once power-down is released and the PLL reports lock. In `ST_FILL` the block sends a set number of frames of pseudo-random filler from a 15-bit LFSR. The transition *fill_done* then goes to `ST_DATA`, where captured words are framed. From either active state, the transition *drop* returns to `ST_IDLE` when power-down is asserted or lock is lost. The *drop* clears the disparity, the LFSR and the filler count. The output enable only gates the valid flag and leaves the sequence running. The valid flag stands in for a high-impedance driver.

Top module: `dcb_frame_serializer`

## Requirements
- R1: While active, frames of 28 bits follow back to back with no gap, one bit per clock. The order is: high marker, payload bits 0 to 11, balance bit, parity bit, payload bits 12 to 23, low marker.
- R2: The first bit of every frame is 1 and the last bit is 0.
- R3: Let the raw payload disparity be (2 × ones − 24). The payload is sent inverted, with the balance bit at 1, exactly when this disparity and the running disparity are both strictly positive or both strictly negative. Otherwise the payload is sent unchanged with the balance bit at 0.
- R4: After each frame, the running disparity (starting at 0) adds the disparity of the transmitted payload. It never leaves the range −24 to +24.
- R5: The parity bit makes the count of ones over the 24 transmitted payload bits, the balance bit and the parity bit even.
- R6: With `cap_rise` high, the parallel word is captured on a rising edge of `pclk`. With `cap_rise` low, it is captured on a falling edge. A data frame carries the word captured most recently before the frame starts.
- R7: `ser_valid` is high only while `pwr_n`, `pll_locked` and `out_en` are all high and the link is active. Dropping `out_en` does not restart or pause the frame sequence.
- R8: Asserting power-down or losing lock returns the block to idle. The next start sends filler again from the LFSR seed, with the running disparity back at 0.
- R9: The first INIT_FRAMES frames after a start carry filler and are encoded like data. The filler payload is {s[14:6], s[14:0]}, where s is an LFSR state that starts at 15'h0001. The state advances once per filler frame by shifting left and inserting s[14]^s[13]. Data frames follow the filler.
- R10: The first frame's high marker appears in the cycle after the first clock edge at which `pwr_n` and `pll_locked` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, 28 times the parallel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pclk | input | 1 | Parallel clock, sampled by `clk` |
| cap_rise | input | 1 | 1: capture on rising `pclk` edge, 0: on falling edge |
| din | input | 24 | Parallel payload word |
| out_en | input | 1 | Output enable, gates `ser_valid` only |
| pwr_n | input | 1 | Active-low power-down |
| pll_locked | input | 1 | Lock indication from the PLL model |
| ser_out | output | 1 | Serial frame bit |
| ser_valid | output | 1 | High when `ser_out` is driven, low for high impedance |

## Verification
Words with all ones and all zeros drive the payload disparity to its extremes. They show whether the balance bit alternates as the running total crosses zero, and whether the total stays within its range. A word with balanced disparity must never be inverted, which separates a strict sign test from a non-strict one. Pairs of words presented across the two `pclk` edges, with random edge selection, separate rising-edge capture from falling-edge capture. Power-down and lock loss in the middle of a frame, together with toggling of `out_en` during filler, show whether the filler restarts from its seed and whether the enable only gates the valid flag.

// File: rtl/dcb_ser_pkg.sv
package dcb_ser_pkg;
    localparam int PAY_W   = 24;
    localparam int HALF_W  = PAY_W / 2;
    localparam int FRAME_W = PAY_W + 4;
    localparam int IDX_W   = $clog2(FRAME_W);
    localparam int RD_W    = 7;
    localparam int LFSR_W  = 15;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_DATA = 2'd2
    } ser_state_t;
endpackage

// File: rtl/dcb_capture.sv
module dcb_capture
    import dcb_ser_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pclk,
    input  logic             cap_rise,
    input  logic [PAY_W-1:0] din,
    output logic [PAY_W-1:0] word
);
    logic p_q, p_q2, take;

    always_comb begin
        take = cap_rise ? (p_q & ~p_q2) : (~p_q & p_q2);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q  <= 1'b0;
            p_q2 <= 1'b0;
            word <= '0;
        end else begin
            p_q  <= pclk;
            p_q2 <= p_q;
            if (take) word <= din;
        end
    end
endmodule

// File: rtl/dcb_filler_lfsr.sv
module dcb_filler_lfsr
    import dcb_ser_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 15'h0001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    output logic [PAY_W-1:0] fill_word
);
    logic [LFSR_W-1:0] s_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    s_q <= SEED;
        else if (clr)  s_q <= SEED;
        else if (step) s_q <= {s_q[LFSR_W-2:0], s_q[14] ^ s_q[13]};
    end

    assign fill_word = {s_q[14:6], s_q};
endmodule

// File: rtl/dcb_frame_encoder.sv
module dcb_frame_encoder
    import dcb_ser_pkg::*;
(
    input  logic [PAY_W-1:0]       raw,
    input  logic signed [RD_W-1:0] rd_in,
    output logic [FRAME_W-1:0]     frame,
    output logic signed [RD_W-1:0] rd_out
);
    int ones_n, pd, rdi;
    logic inv, par;
    logic [PAY_W-1:0] tx;

    always_comb begin
        ones_n = 0;
        for (int i = 0; i < PAY_W; i++) ones_n += int'(raw[i]);
        pd  = 2 * ones_n - PAY_W;
        rdi = int'(rd_in);
        inv = (pd > 0 && rdi > 0) || (pd < 0 && rdi < 0);
        tx  = inv ? ~raw : raw;
        par = ^{tx, inv};
        rd_out = RD_W'(inv ? rdi - pd : rdi + pd);
        frame = {1'b0, tx[PAY_W-1:HALF_W], par, inv, tx[HALF_W-1:0], 1'b1};
    end
endmodule

// File: rtl/dcb_frame_serializer.sv
module dcb_frame_serializer
    import dcb_ser_pkg::*;
#(
    parameter int INIT_FRAMES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pclk,
    input  logic             cap_rise,
    input  logic [23:0]      din,
    input  logic             out_en,
    input  logic             pwr_n,
    input  logic             pll_locked,
    output logic             ser_out,
    output logic             ser_valid
);
    localparam int FC_W = $clog2(INIT_FRAMES + 1);
    localparam logic [FC_W-1:0]  FC_LAST  = FC_W'(INIT_FRAMES - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_W - 1);

    ser_state_t state, state_nx;
    logic run_ok, last_bit, load, src_fill;
    logic [IDX_W-1:0] bit_idx;
    logic [FC_W-1:0] fill_cnt;
    logic [FRAME_W-1:0] shreg, frame;
    logic signed [RD_W-1:0] rd_q, rd_nx;
    logic [PAY_W-1:0] cap_word, fill_word, raw;

    dcb_capture u_cap (
        .clk(clk), .rst_n(rst_n), .pclk(pclk), .cap_rise(cap_rise),
        .din(din), .word(cap_word)
    );

    dcb_filler_lfsr u_lfsr (
        .clk(clk), .rst_n(rst_n), .clr(!run_ok), .step(load && src_fill),
        .fill_word(fill_word)
    );

    assign raw = src_fill ? fill_word : cap_word;

    dcb_frame_encoder u_enc (
        .raw(raw), .rd_in(rd_q), .frame(frame), .rd_out(rd_nx)
    );

    assign run_ok   = pwr_n && pll_locked;
    assign last_bit = (bit_idx == IDX_LAST);
    assign src_fill = (state == ST_IDLE) ||
                      (state == ST_FILL && fill_cnt != FC_LAST);
    assign load     = run_ok && ((state == ST_IDLE) || last_bit);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (run_ok) state_nx = ST_FILL;
            ST_FILL: begin
                if (!run_ok) state_nx = ST_IDLE;
                else if (last_bit && fill_cnt == FC_LAST) state_nx = ST_DATA;
            end
            ST_DATA: if (!run_ok) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            bit_idx  <= '0;
            fill_cnt <= '0;
            rd_q     <= '0;
        end else if (!run_ok) begin
            shreg    <= '0;
            bit_idx  <= '0;
            fill_cnt <= '0;
            rd_q     <= '0;
        end else if (load) begin
            shreg   <= frame;
            bit_idx <= '0;
            rd_q    <= rd_nx;
            if (state == ST_FILL) fill_cnt <= fill_cnt + 1'b1;
        end else if (state != ST_IDLE) begin
            shreg   <= shreg >> 1;
            bit_idx <= bit_idx + 1'b1;
        end
    end

    // outputs
    always_comb begin
        ser_out   = shreg[0];
        ser_valid = (state != ST_IDLE) && out_en && run_ok;
    end
endmodule

// File: rtl/dcb_frame_checker.sv
module dcb_frame_checker
    import dcb_ser_pkg::*;
#(
    parameter int INIT_FRAMES = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   pwr_n,
    input logic                   pll_locked,
    input ser_state_t             state,
    input logic [IDX_W-1:0]       bit_idx,
    input logic                   ser_out,
    input logic signed [RD_W-1:0] rd_q,
    input logic [$clog2(INIT_FRAMES+1)-1:0] fill_cnt
);
    assert_marker_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && bit_idx == 0) |-> ser_out == 1'b1);

    assert_marker_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && bit_idx == IDX_W'(FRAME_W - 1)) |-> ser_out == 1'b0);

    assert_disparity_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_q <= 24) && (rd_q >= -24));

    assert_powerdown_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_n || !pll_locked) |=> state == ST_IDLE);

    assert_fill_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_DATA) |-> $past(fill_cnt) == ($clog2(INIT_FRAMES+1))'(INIT_FRAMES - 1));

    assert_bit_advance_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE && bit_idx != 0)
            |-> bit_idx == $past(bit_idx) + 1'b1);
endmodule

bind dcb_frame_serializer dcb_frame_checker #(.INIT_FRAMES(INIT_FRAMES)) i_chk (
    .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .pll_locked(pll_locked),
    .state(state), .bit_idx(bit_idx), .ser_out(ser_out), .rd_q(rd_q),
    .fill_cnt(fill_cnt)
);

// File: tb/test_dcb_frame_serializer.sv
`timescale 1ns/1ps
module test_dcb_frame_serializer;
    localparam int INIT = 4;

    logic clk = 0, rst_n = 0, pclk = 0, cap_rise = 1, out_en = 1;
    logic pwr_n = 0, pll_locked = 0;
    logic [23:0] din = '0;
    logic ser_out, ser_valid;

    int checks = 0, errors = 0;
    bit done = 0;

    bit mon_on = 0;
    int mon_pos, mrd, mfill;
    logic [14:0] mlfsr;
    logic [27:0] fr;
    bit exp_known = 0;
    logic [23:0] exp_word;
    string exp_req = "R6";

    always #5 clk = ~clk;

    dcb_frame_serializer #(.INIT_FRAMES(INIT)) i_dcb_frame_serializer (
        .clk(clk), .rst_n(rst_n), .pclk(pclk), .cap_rise(cap_rise), .din(din),
        .out_en(out_en), .pwr_n(pwr_n), .pll_locked(pll_locked),
        .ser_out(ser_out), .ser_valid(ser_valid)
    );

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int ones24(logic [23:0] w);
        int n = 0;
        for (int i = 0; i < 24; i++) n += int'(w[i]);
        return n;
    endfunction

    function automatic logic [14:0] lstep(logic [14:0] s);
        return {s[13:0], s[14] ^ s[13]};
    endfunction

    function automatic bit same_sign(int a, int b);
        return (a > 0 && b > 0) || (a < 0 && b < 0);
    endfunction

    task automatic frame_done();
        logic [23:0] obs, raw;
        logic bal, par;
        int pd;
        chk(fr[0] == 1'b1 && fr[27] == 1'b0, "R2", {fr[27], fr[0]}, 2'b01);
        obs = {fr[26:15], fr[12:1]};
        bal = fr[13];
        par = fr[14];
        chk((^{obs, bal, par}) == 1'b0, "R5", par, ^{obs, bal});
        pd = 2 * ones24(obs) - 24;
        chk(bal == same_sign(bal ? -pd : pd, mrd), "R3", bal, same_sign(bal ? -pd : pd, mrd));
        mrd += pd;
        chk(mrd <= 24 && mrd >= -24, "R4", mrd, 0);
        raw = bal ? ~obs : obs;
        if (mfill < INIT) begin
            chk(raw == {mlfsr[14:6], mlfsr}, "R9", raw, {mlfsr[14:6], mlfsr});
            mlfsr = lstep(mlfsr);
            mfill++;
        end else if (exp_known) begin
            chk(raw == exp_word, exp_req, raw, exp_word);
        end
    endtask

    // monitor: samples away from the active edge
    always @(negedge clk) begin
        if (mon_on) begin
            fr[mon_pos] = ser_out;
            chk(ser_valid == out_en, "R7", ser_valid, out_en);
            if (mon_pos == 27) begin
                frame_done();
                mon_pos = 0;
            end else mon_pos++;
        end
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // R10: first frame's high marker follows the enabling edge by one cycle
    task automatic start_link();
        cyc(1);
        pwr_n = 1;
        pll_locked = 1;
        @(posedge clk);
        #1;
        mon_pos = 0; mrd = 0; mfill = 0; mlfsr = 15'h0001;
        mon_on = 1;
        #1;
    endtask

    task automatic stop_link(bit by_lock);
        cyc(1);
        if (by_lock) pll_locked = 0; else pwr_n = 0;
        mon_on = 0;
        #1;
        chk(ser_valid == 1'b0, "R7", ser_valid, 0);
        cyc(3);
        chk(ser_valid == 1'b0, "R8", ser_valid, 0);
        if (by_lock) pll_locked = 1; else pwr_n = 1;
        pll_locked = 0;
        cyc(2);
    endtask

    // present A before the rising edge and B before the falling edge
    task automatic present(logic [23:0] a, logic [23:0] b, bit sel, string req);
        exp_known = 0;
        cap_rise = sel;
        pclk = 0; din = a; cyc(3);
        pclk = 1; cyc(3);
        din = b; cyc(3);
        pclk = 0; cyc(3);
        exp_word = sel ? a : b;
        exp_req = req;
        cyc(60);
        exp_known = 1;
        cyc(28 * 4);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(3);
        chk(ser_valid == 1'b0, "R7", ser_valid, 0);
        rst_n = 1;
        cyc(2);
        pwr_n = 1;
        cyc(5);
        chk(ser_valid == 1'b0, "R7", ser_valid, 0);
        pwr_n = 0;
        start_link();
        // R7: out_en gating during filler must not restart sequence
        cyc(20);
        out_en = 0;
        cyc(40);
        out_en = 1;
        cyc(28 * INIT);
        // R3 R4: extreme disparity words, R6 rising capture
        present(24'hFFFFFF, 24'h000000, 1'b1, "R6");
        present(24'hFFFFFF, 24'h000000, 1'b0, "R6");
        present(24'h000FFF, 24'h0F0F0F, 1'b1, "R3");
        present(24'h123456, 24'hA5A5A5, 1'b0, "R6");
        // R8: lock loss mid-frame, filler restarts
        cyc(13);
        stop_link(1'b1);
        start_link();
        cyc(28 * (INIT + 1));
        present(24'hF0F0FF, 24'h00FF01, 1'b1, "R6");
        // R8: power-down mid-frame
        cyc(7);
        stop_link(1'b0);
        start_link();
        for (int i = 0; i < 30; i++) begin
            logic [23:0] a, b;
            a = 24'($urandom);
            b = 24'($urandom);
            if (i % 5 == 0) a = 24'hFFFFFF;
            out_en = 1'($urandom);
            present(a, b, 1'($urandom), "R6");
            out_en = 1;
            if (i == 15) begin
                stop_link(1'b0);
                start_link();
            end
        end
        cyc(5);
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5678));
    end
endmodule